// File: doc/BRIEF.md
# NAND Command and Address Input Stage

This block is the receiving end of an 8-bit multiplexed NAND bus inside a flash device. It watches the shared byte lane together with the write strobe, the read strobe, the chip select and the two latch-select lines, all sampled on the system clock. When the write strobe rises while the command-latch line is high, the byte is kept as the current command. When the address-latch line is high, the byte is steered into the column or the row according to how many address bytes have arrived since the last command.

A complete address is five bytes: two column bytes followed by three row bytes. The row is split into page, plane and block fields, and the reserved upper bits of the second and fifth bytes are dropped. Any nonzero reserved bit raises an error flag that stays set until reset. The stored column also acts as the read pointer. Each falling read strobe moves it forward by one byte, and it stops at the last spare byte of the page.

Top module: `nand_cmd_addr_in`

## Requirements
- R1: A rising write strobe with chip select low, command-latch high and address-latch low stores the byte as `cmd_out`. It also restarts the address byte count at zero and clears `addr_done`.
- R2: With address-latch high and command-latch low, the first address byte loads column bits 7:0. The second loads column bits 11:8 from bus bits 3:0.
- R3: The third address byte loads the page from bus bits 5:0, the plane from bit 6 and block bit 0 from bit 7. The fourth loads block bits 8:1. The fifth loads block bits 12:9 from bus bits 3:0. `row_out` equals {block, plane, page}.
- R4: `addr_done` rises only when the fifth address byte is latched. Further address bytes change nothing until the next command.
- R5: A nonzero value in bus bits 7:4 of the second or fifth address byte sets `rsv_err`. The flag stays set until reset, and those bits never reach the stored fields.
- R6: Each falling read strobe with chip select low adds one to the column.
- R7: A read strobe leaves the column unchanged when it is at or above COL_LAST (default 2175).
- R8: While chip select is high, write and read strobes change nothing.
- R9: A write strobe with both latch lines high is ignored.
- R10: After reset the command, column, row, `addr_done` and `rsv_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command-latch select |
| ale | input | 1 | Address-latch select |
| we_n | input | 1 | Write strobe; a rising edge latches the bus |
| re_n | input | 1 | Read strobe; a falling edge advances the column |
| io_in | input | 8 | Shared command/address byte lane |
| cmd_out | output | 8 | Last latched command |
| col_out | output | 12 | Column / read pointer |
| row_out | output | 20 | {block, plane, page} |
| page_out | output | 6 | Page within block |
| plane_out | output | 1 | Plane select bit |
| block_out | output | 13 | Block number |
| addr_done | output | 1 | Five address bytes received |
| rsv_err | output | 1 | Sticky reserved-bit error |

## Verification
Strobe edges are found by comparing each strobe with its value one clock earlier. A strobe that changes level just before a clock edge is therefore acted on at that same edge, and every output shows the effect right after it. The bench drives each strobe level at a falling clock edge and holds it for a full period. It reads results only at the falling edge that follows the rising edge on which the strobe edge was seen. As a result, every command, address byte and read-pointer step is checked exactly one clock after the strobe changes.

// File: rtl/nand_cmd_addr_in.sv
module nand_cmd_addr_in #(
  parameter int COL_LAST = 2175
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        cle,
  input  logic        ale,
  input  logic        we_n,
  input  logic        re_n,
  input  logic [7:0]  io_in,
  output logic [7:0]  cmd_out,
  output logic [11:0] col_out,
  output logic [19:0] row_out,
  output logic [5:0]  page_out,
  output logic        plane_out,
  output logic [12:0] block_out,
  output logic        addr_done,
  output logic        rsv_err
);
  localparam int COL_W    = 12;
  localparam int PAGE_W   = 6;
  localparam int BLK_W    = 13;
  localparam int ADDR_CYC = 5;
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(COL_LAST);

  logic              we_q, re_q;
  logic [2:0]        cyc;
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;
  logic              plane;
  logic [BLK_W-1:0]  block;
  logic              wr_edge, cmd_wr, adr_wr, rd_step;

  assign wr_edge = we_n & ~we_q & ~ce_n;
  assign cmd_wr  = wr_edge & cle & ~ale;
  assign adr_wr  = wr_edge & ale & ~cle & (cyc < 3'(ADDR_CYC));
  assign rd_step = ~re_n & re_q & ~ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_out   <= '0;
      cyc       <= '0;
      addr_done <= 1'b0;
      rsv_err   <= 1'b0;
      page      <= '0;
      plane     <= 1'b0;
      block     <= '0;
    end else if (cmd_wr) begin
      cmd_out   <= io_in;
      cyc       <= '0;
      addr_done <= 1'b0;
    end else if (adr_wr) begin
      cyc <= cyc + 3'd1;
      case (cyc)
        3'd1: if (io_in[7:4] != 4'h0) rsv_err <= 1'b1;
        3'd2: begin
          page     <= io_in[5:0];
          plane    <= io_in[6];
          block[0] <= io_in[7];
        end
        3'd3: block[8:1] <= io_in;
        3'd4: begin
          block[12:9] <= io_in[3:0];
          addr_done   <= 1'b1;
          if (io_in[7:4] != 4'h0) rsv_err <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      col <= '0;
    else if (adr_wr && cyc == 3'd0)
      col[7:0] <= io_in;
    else if (adr_wr && cyc == 3'd1)
      col[11:8] <= io_in[3:0];
    else if (rd_step && col < COL_MAX)
      col <= col + 1'b1;
  end

  assign col_out   = col;
  assign page_out  = page;
  assign plane_out = plane;
  assign block_out = block;
  assign row_out   = {block, plane, page};

  assert_cmd_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cyc == 3'd0 && !addr_done));

  assert_done_on_fifth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_done) |-> $past(cyc) == 3'd4);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_err |=> rsv_err);

  assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !adr_wr && col < COL_MAX) |=> col == COL_W'($past(col) + 1'b1));

  assert_col_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !adr_wr && col >= COL_MAX) |=> $stable(col));

  assert_deselect_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> ($stable(cmd_out) && $stable(col) && $stable(row_out) && $stable(rsv_err)));
endmodule

// File: tb/nand_cmd_addr_in_test.sv
module nand_cmd_addr_in_test;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b0, cle = 1'b0, ale = 1'b0;
  logic we_n = 1'b1, re_n = 1'b1;
  logic [7:0] io_in = '0;
  logic [7:0] cmd_out;
  logic [11:0] col_out;
  logic [19:0] row_out;
  logic [5:0] page_out;
  logic plane_out, addr_done, rsv_err;
  logic [12:0] block_out;
  int total = 0, bad = 0;

  nand_cmd_addr_in uut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_in(io_in), .cmd_out(cmd_out), .col_out(col_out),
    .row_out(row_out), .page_out(page_out), .plane_out(plane_out),
    .block_out(block_out), .addr_done(addr_done), .rsv_err(rsv_err));

  always #2 clk = ~clk;

  // {b4,b3,b2,b1,b0, col, row, err}
  localparam logic [72:0] VEC [4] = '{
    {40'h00_00_00_00_00, 12'h000, 20'h00000, 1'b0},
    {40'h00_00_3F_08_7F, 12'h87F, 20'h0003F, 1'b0},
    {40'h0C_5A_C1_03_A5, 12'h3A5, 20'hC5AC1, 1'b0},
    {40'hFF_FF_80_F7_FF, 12'h7FF, 20'hFFF80, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; io_in = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic send_addr(input logic [39:0] b);
    for (int i = 0; i < 5; i++) bus_wr(1'b0, 1'b1, b[8*i +: 8]);
  endtask

  task automatic rd_pulse;
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); re_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad + 0);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 cmd", cmd_out, 0);
    chk("R10 col", col_out, 0);
    chk("R10 row", row_out, 0);
    chk("R10 done", addr_done, 0);
    chk("R10 err", rsv_err, 0);

    for (int v = 0; v < 4; v++) begin
      do_reset();
      bus_wr(1'b1, 1'b0, 8'h00);
      send_addr(VEC[v][72:33]);
      chk("R2 col", col_out, VEC[v][32:21]);
      chk("R3 row", row_out, VEC[v][20:1]);
      chk("R3 page", page_out, VEC[v][6:1]);
      chk("R3 plane", plane_out, VEC[v][7]);
      chk("R3 block", block_out, VEC[v][20:8]);
      chk("R4 done", addr_done, 1);
      chk("R5 err", rsv_err, VEC[v][0]);
    end

    do_reset();
    bus_wr(1'b1, 1'b0, 8'h90);
    chk("R1 cmd", cmd_out, 8'h90);
    bus_wr(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 4; i++) bus_wr(1'b0, 1'b1, i == 0 ? 8'h12 : 8'h00);
    chk("R4 done early", addr_done, 0);
    bus_wr(1'b0, 1'b1, 8'h00);
    chk("R4 done fifth", addr_done, 1);
    bus_wr(1'b0, 1'b1, 8'h55);
    chk("R4 sixth ignored col", col_out, 12'h012);
    chk("R4 sixth ignored row", row_out, 0);

    bus_wr(1'b1, 1'b0, 8'h00);
    bus_wr(1'b0, 1'b1, 8'h34);
    bus_wr(1'b0, 1'b1, 8'h01);
    bus_wr(1'b1, 1'b0, 8'h30);
    chk("R1 done cleared", addr_done, 0);
    send_addr(40'h00_00_02_00_10);
    chk("R1 restart col", col_out, 12'h010);
    chk("R1 restart row", row_out, 20'h00002);

    bus_wr(1'b1, 1'b1, 8'hAA);
    chk("R9 cmd", cmd_out, 8'h30);
    chk("R9 col", col_out, 12'h010);

    ce_n = 1'b1;
    bus_wr(1'b1, 1'b0, 8'hFF);
    rd_pulse();
    @(negedge clk);
    chk("R8 cmd", cmd_out, 8'h30);
    chk("R8 col", col_out, 12'h010);
    ce_n = 1'b0;

    rd_pulse(); rd_pulse(); rd_pulse();
    chk("R6 col step", col_out, 12'h013);

    bus_wr(1'b1, 1'b0, 8'h00);
    send_addr(40'h00_00_00_08_7E);
    rd_pulse(); rd_pulse(); rd_pulse();
    chk("R7 cap", col_out, 12'h87F);

    bus_wr(1'b1, 1'b0, 8'h00);
    send_addr(40'h00_00_00_0F_FF);
    rd_pulse();
    chk("R7 above cap", col_out, 12'hFFF);

    do_reset();
    bus_wr(1'b1, 1'b0, 8'h00);
    send_addr(40'h00_00_00_13_00);
    chk("R5 err col2", rsv_err, 1);
    chk("R5 col masked", col_out, 12'h300);
    bus_wr(1'b1, 1'b0, 8'h00);
    send_addr(40'h00_00_00_00_00);
    chk("R5 err sticky", rsv_err, 1);
    do_reset();
    chk("R5 err reset", rsv_err, 0);
    bus_wr(1'b1, 1'b0, 8'h00);
    send_addr(40'h21_00_00_00_00);
    chk("R5 err col5", rsv_err, 1);
    chk("R5 block masked", block_out, 13'h0200);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule